// File: doc/BRIEF.md
# Vector floating-point to unsigned fixed-point converter

This block takes a 128-bit register of IEEE-754 floating-point elements and turns each element into an unsigned fixed-point number. Every element is multiplied by two to the power of a fractional-bit count and then truncated, which rounds toward zero. The element format can be half, single or double precision. The 7-bit immediate that selects the format, written as a 4-bit upper field and a 3-bit lower field, also carries the scale. A wide-register bit chooses between a 64-bit and a 128-bit vector. A scalar select reduces the operation to lane 0.

All lanes convert in parallel in one combinational pass. The results are captured in a single output register. Invalid and inexact conditions are ORed over the active lanes and collected in sticky flags, which only reset clears. An encoding that the immediate, the wide bit or the scalar select does not allow raises a one-cycle undefined pulse and changes nothing else.

Top module: `vfp_ufix_cvt`

## Requirements
- R1: The upper immediate field `imm_hi` selects the element width. Bit 3 set gives 64 bits (double). Otherwise bit 2 set gives 32 bits (single). Otherwise the width is 16 bits (half).
- R2: Let code = {imm_hi, imm_lo} read as an unsigned 7-bit number. The fractional-bit count is 2*width - code, which lies between 1 and the element width.
- R3: The encoding is undefined when `imm_hi[3:1]` is 000, when `imm_hi[3:2]` is 00 and HALF_EN is 0, or in vector form when `imm_hi[3]` is 1 and `q_full` is 0. For an undefined encoding, `undef` is high in the cycle after `in_valid`, and the result and both flags keep their values.
- R4: In vector form the active region is 64 bits when `q_full` is 0 and 128 bits when it is 1. The active lanes are those that fit in that region, counted from bit 0. Bits above the region are zero.
- R5: In scalar form only lane 0 is converted. The bits above lane 0 come from `dst_old` when `merge_en` is 1 and are zero when it is 0.
- R6: A positive finite element x gives floor(x * 2^fbits) whenever that value is below 2^width.
- R7: A negative element gives 0. If |x * 2^fbits| >= 1, the invalid flag is set. Otherwise, if x is nonzero, the inexact flag is set. Both +0 and -0 give 0 and set no flag.
- R8: A NaN gives 0 and sets invalid. A positive value with x * 2^fbits >= 2^width, including +infinity, gives all ones and sets invalid. Negative infinity gives 0 and sets invalid.
- R9: Inexact is set when a lane without an invalid condition discards nonzero fraction bits.
- R10: Both flags are sticky and are cleared only by reset. Each flag is the OR over the active lanes of accepted operations. Inactive lanes never contribute.
- R11: `out_valid` follows `in_valid` one cycle later. `result` changes only in the cycle after an accepted operation. After reset, `result`, `out_valid`, `undef` and both flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | An operation is presented this cycle |
| src_vec | input | VW | Source elements, lane 0 in the low bits |
| imm_hi | input | 4 | Upper immediate field: element width and high scale bits |
| imm_lo | input | 3 | Lower immediate field: low scale bits |
| q_full | input | 1 | Vector form: 1 selects the 128-bit register, 0 the 64-bit register |
| scalar | input | 1 | 1 selects scalar form (lane 0 only) |
| merge_en | input | 1 | Scalar form: keep the upper bits of dst_old |
| dst_old | input | VW | Previous destination value, used for merging |
| out_valid | output | 1 | Result of the previous cycle's operation is present |
| result | output | VW | Registered converted vector |
| undef | output | 1 | The previous cycle's operation was an undefined encoding |
| flag_invalid | output | 1 | Sticky invalid-operation flag |
| flag_inexact | output | 1 | Sticky inexact flag |

## Verification
The output register is loaded only on accepted operations. A decode error in width, scale or lane count therefore shows up in the very next cycle as a wrong lane value, or as nonzero bits where lanes should be inactive. A wrong merge choice shows up in that same cycle, in the bits above lane 0. The flags hold their state until reset, so one wrongly raised flag stays visible on every later cycle until reset; short directed groups separated by resets keep each group's flag outcome observable. A missed undefined encoding shows up at once, as a result change or a missing `undef` pulse, on the cycle after the operation.

// File: rtl/ufx_pkg.sv
package ufx_pkg;
  typedef enum logic [1:0] {
    ESZ_H = 2'd0,
    ESZ_S = 2'd1,
    ESZ_D = 2'd2
  } esz_e;
endpackage

// File: rtl/ufx_decode.sv
module ufx_decode
  import ufx_pkg::*;
#(
  parameter bit HALF_EN = 1'b1
) (
  input  logic [3:0] imm_hi,
  input  logic [2:0] imm_lo,
  input  logic       q_full,
  input  logic       scalar,
  output esz_e       esz,
  output logic [6:0] fbits,
  output logic [3:0] lanes,
  output logic       undef
);
  logic [6:0] code;

  always_comb begin
    code = {imm_hi, imm_lo};
    if (imm_hi[3]) begin
      esz   = ESZ_D;
      fbits = 7'd0 - code;            // 128 - code, modulo 128
      lanes = scalar ? 4'd1 : 4'd2;
    end else if (imm_hi[2]) begin
      esz   = ESZ_S;
      fbits = 7'd64 - code;
      lanes = scalar ? 4'd1 : (q_full ? 4'd4 : 4'd2);
    end else begin
      esz   = ESZ_H;
      fbits = 7'd32 - code;
      lanes = scalar ? 4'd1 : (q_full ? 4'd8 : 4'd4);
    end
    undef = (imm_hi[3:1] == 3'b000)
         || (!HALF_EN && (imm_hi[3:2] == 2'b00))
         || (!scalar && imm_hi[3] && !q_full);
  end
endmodule

// File: rtl/ufx_lane.sv
module ufx_lane #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52
) (
  input  logic [EXP_W+MAN_W:0] elem,
  input  logic [6:0]           fbits,
  output logic [EXP_W+MAN_W:0] val,
  output logic                 inv,
  output logic                 inx
);
  localparam int EW   = 1 + EXP_W + MAN_W;
  localparam int SIGW = MAN_W + 1;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int SHW  = 14;
  localparam logic signed [SHW-1:0] BIAS_S = SHW'(BIAS);
  localparam logic signed [SHW-1:0] MAN_S  = SHW'(MAN_W);
  localparam logic signed [SHW-1:0] EW_S   = SHW'(EW);
  localparam logic signed [SHW-1:0] ONE_S  = SHW'(1);

  logic                  sgn, exp_max, is_zero, over, lost;
  logic [EXP_W-1:0]      ex;
  logic [MAN_W-1:0]      mn;
  logic [SIGW-1:0]       sig, q_r, back;
  logic signed [SHW-1:0] ee, scale, sh, neg_sh;
  logic [SHW-1:0]        amt;
  logic [EW-1:0]         mag;

  always_comb begin
    sgn     = elem[EW-1];
    ex      = elem[EW-2:MAN_W];
    mn      = elem[MAN_W-1:0];
    exp_max = &ex;
    is_zero = (ex == '0) && (mn == '0);
    sig     = {|ex, mn};
    ee      = (ex == '0) ? (ONE_S - BIAS_S)
                         : ($signed({{(SHW-EXP_W){1'b0}}, ex}) - BIAS_S);
    scale   = ee + $signed({{(SHW-7){1'b0}}, fbits});
    over    = (|ex) && (scale >= EW_S);   // value >= 2^EW once scaled
    sh      = scale - MAN_S;
    neg_sh  = -sh;
    amt     = sh[SHW-1] ? neg_sh : sh;
    if (sh[SHW-1]) begin
      q_r  = sig >> amt;
      back = q_r << amt;
      lost = (back != sig);
      mag  = EW'(q_r);
    end else begin
      q_r  = sig;
      back = sig;
      lost = 1'b0;
      mag  = {{(EW-SIGW){1'b0}}, sig} << amt;
    end

    val = '0;
    inv = 1'b0;
    inx = 1'b0;
    if (exp_max) begin
      inv = 1'b1;
      if ((mn == '0) && !sgn) val = '1;
    end else if (is_zero) begin
      val = '0;
    end else if (sgn) begin
      if (over || (mag != '0)) inv = 1'b1;
      else                     inx = lost;
    end else if (over) begin
      val = '1;
      inv = 1'b1;
    end else begin
      val = mag;
      inx = lost;
    end
  end
endmodule

// File: rtl/vfp_ufix_cvt.sv
module vfp_ufix_cvt
  import ufx_pkg::*;
#(
  parameter int VW      = 128,
  parameter bit HALF_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [VW-1:0] src_vec,
  input  logic [3:0]    imm_hi,
  input  logic [2:0]    imm_lo,
  input  logic          q_full,
  input  logic          scalar,
  input  logic          merge_en,
  input  logic [VW-1:0] dst_old,
  output logic          out_valid,
  output logic [VW-1:0] result,
  output logic          undef,
  output logic          flag_invalid,
  output logic          flag_inexact
);
  localparam int NH = VW / 16;
  localparam int NS = VW / 32;
  localparam int ND = VW / 64;

  esz_e       dec_esz;
  logic [6:0] dec_fbits;
  logic [3:0] dec_lanes;
  logic       dec_undef;

  ufx_decode #(.HALF_EN(HALF_EN)) u_dec (
    .imm_hi(imm_hi), .imm_lo(imm_lo), .q_full(q_full), .scalar(scalar),
    .esz(dec_esz), .fbits(dec_fbits), .lanes(dec_lanes), .undef(dec_undef)
  );

  logic [15:0] h_val [NH];
  logic [31:0] s_val [NS];
  logic [63:0] d_val [ND];
  logic [NH-1:0] h_inv, h_inx;
  logic [NS-1:0] s_inv, s_inx;
  logic [ND-1:0] d_inv, d_inx;

  for (genvar g = 0; g < NH; g++) begin : g_half
    ufx_lane #(.EXP_W(5), .MAN_W(10)) u_lane (
      .elem(src_vec[16*g +: 16]), .fbits(dec_fbits),
      .val(h_val[g]), .inv(h_inv[g]), .inx(h_inx[g]));
  end
  for (genvar g = 0; g < NS; g++) begin : g_single
    ufx_lane #(.EXP_W(8), .MAN_W(23)) u_lane (
      .elem(src_vec[32*g +: 32]), .fbits(dec_fbits),
      .val(s_val[g]), .inv(s_inv[g]), .inx(s_inx[g]));
  end
  for (genvar g = 0; g < ND; g++) begin : g_double
    ufx_lane #(.EXP_W(11), .MAN_W(52)) u_lane (
      .elem(src_vec[64*g +: 64]), .fbits(dec_fbits),
      .val(d_val[g]), .inv(d_inv[g]), .inx(d_inx[g]));
  end

  logic [VW-1:0] nxt_res, res_q;
  logic          any_inv, any_inx, upd;
  logic          vld_d, und_d, inv_d, inx_d;
  logic          vld_q, und_q, inv_q, inx_q;

  // lane assembly: inactive lanes keep the base (zero or merged old value)
  always_comb begin
    nxt_res = (scalar && merge_en) ? dst_old : '0;
    any_inv = 1'b0;
    any_inx = 1'b0;
    unique case (dec_esz)
      ESZ_H: for (int i = 0; i < NH; i++) if (i < int'(dec_lanes)) begin
        nxt_res[16*i +: 16] = h_val[i];
        any_inv = any_inv | h_inv[i];
        any_inx = any_inx | h_inx[i];
      end
      ESZ_S: for (int i = 0; i < NS; i++) if (i < int'(dec_lanes)) begin
        nxt_res[32*i +: 32] = s_val[i];
        any_inv = any_inv | s_inv[i];
        any_inx = any_inx | s_inx[i];
      end
      ESZ_D: for (int i = 0; i < ND; i++) if (i < int'(dec_lanes)) begin
        nxt_res[64*i +: 64] = d_val[i];
        any_inv = any_inv | d_inv[i];
        any_inx = any_inx | d_inx[i];
      end
      default: ;
    endcase
  end

  // next state
  always_comb begin
    upd   = in_valid && !dec_undef;
    vld_d = in_valid;
    und_d = in_valid && dec_undef;
    inv_d = inv_q | (upd & any_inv);
    inx_d = inx_q | (upd & any_inx);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      und_q <= 1'b0;
      inv_q <= 1'b0;
      inx_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      und_q <= und_d;
      inv_q <= inv_d;
      inx_q <= inx_d;
      if (upd) res_q <= nxt_res;
    end
  end

  assign out_valid    = vld_q;
  assign undef        = und_q;
  assign result       = res_q;
  assign flag_invalid = inv_q;
  assign flag_inexact = inx_q;
endmodule

// File: rtl/ufx_chk.sv
module ufx_chk #(
  parameter int VW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [3:0]    imm_hi,
  input logic          q_full,
  input logic          scalar,
  input logic          merge_en,
  input logic          out_valid,
  input logic [VW-1:0] result,
  input logic          undef,
  input logic          flag_invalid,
  input logic          flag_inexact
);
  p_valid_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !undef && $stable(result)));

  p_undef_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> ($stable(result) && $stable(flag_invalid) && $stable(flag_inexact) && out_valid));

  p_undef_q0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !scalar && imm_hi[3] && !q_full) |=> undef);

  p_sticky_inv_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(flag_invalid));

  p_sticky_inx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(flag_inexact));

  p_half_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !scalar && !q_full) |=> (undef || (result[VW-1:VW/2] == '0)));

  p_scalar_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && scalar && !merge_en) |=> (undef || (result[VW-1:VW/2] == '0)));
endmodule

bind vfp_ufix_cvt ufx_chk #(.VW(VW)) u_chk (.*);

// File: tb/tb_vfp_ufix_cvt.sv
module tb_vfp_ufix_cvt;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [127:0] src_vec, dst_old;
  logic [3:0]   imm_hi;
  logic [2:0]   imm_lo;
  logic         q_full, scalar, merge_en;
  logic         out_valid, undef, flag_invalid, flag_inexact;
  logic [127:0] result;
  logic         nh_valid, nh_undef, nh_inv, nh_inx;
  logic [127:0] nh_result;

  always #2.5 clk = ~clk;   // 200 MHz

  vfp_ufix_cvt dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
    .imm_hi(imm_hi), .imm_lo(imm_lo), .q_full(q_full), .scalar(scalar),
    .merge_en(merge_en), .dst_old(dst_old), .out_valid(out_valid),
    .result(result), .undef(undef), .flag_invalid(flag_invalid),
    .flag_inexact(flag_inexact));

  vfp_ufix_cvt #(.HALF_EN(1'b0)) dut_nh (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
    .imm_hi(imm_hi), .imm_lo(imm_lo), .q_full(q_full), .scalar(scalar),
    .merge_en(merge_en), .dst_old(dst_old), .out_valid(nh_valid),
    .result(nh_result), .undef(nh_undef), .flag_invalid(nh_inv),
    .flag_inexact(nh_inx));

  int n_cmp = 0, n_bad = 0;
  logic [127:0] e_res;
  logic e_ov, e_ud, e_nhud, e_inv, e_inx;
  string cur_tag = "R11";

  function automatic real p2(input int k);
    real x = 1.0;
    if (k >= 0) for (int i = 0; i < k; i++) x = x * 2.0;
    else        for (int i = 0; i < -k; i++) x = x / 2.0;
    return x;
  endfunction

  function automatic logic [63:0] r2u(input real t);
    longint v;
    if (t >= p2(63)) begin
      v = longint'(t - p2(63));
      return {1'b1, v[62:0]};
    end
    v = longint'(t);
    return v;
  endfunction

  // behavioural lane model from R6..R9
  function automatic void mlane(input logic [63:0] b, input int es, input int f,
                                output logic [63:0] v, output bit inv, output bit inx);
    int ew, mw, bias, e;
    longint unsigned ex, mn, sig;
    bit sg;
    real r, t;
    ew = (es == 16) ? 5 : (es == 32) ? 8 : 11;
    mw = (es == 16) ? 10 : (es == 32) ? 23 : 52;
    bias = (1 << (ew - 1)) - 1;
    sg = b[es-1];
    ex = (b >> mw) & ((64'd1 << ew) - 1);
    mn = b & ((64'd1 << mw) - 1);
    v = '0; inv = 0; inx = 0;
    if (ex == (64'd1 << ew) - 1) begin
      inv = 1;
      if (mn == 0 && !sg) v = (es == 64) ? '1 : ((64'd1 << es) - 1);
      return;
    end
    e   = (ex == 0) ? 1 - bias : int'(ex) - bias;
    sig = (ex != 0) ? (mn | (64'd1 << mw)) : mn;
    r   = real'(sig) * p2(e - mw + f);
    if (r == 0.0) return;
    t = $floor(r);
    if (sg) begin
      if (t >= 1.0) inv = 1; else inx = 1;
    end else if (r >= p2(es)) begin
      v = (es == 64) ? '1 : ((64'd1 << es) - 1);
      inv = 1;
    end else begin
      v = r2u(t);
      inx = (t != r);
    end
  endfunction

  function automatic bit m_undef(input bit half_ok);
    return (imm_hi[3:1] == 3'b000) || (!half_ok && imm_hi[3:2] == 2'b00)
        || (!scalar && imm_hi[3] && !q_full);
  endfunction

  task automatic model_step();
    int es, f, n, code;
    logic [63:0] v; bit li, lx;
    logic [127:0] r;
    e_ov = in_valid;
    e_ud = in_valid && m_undef(1'b1);
    e_nhud = in_valid && m_undef(1'b0);
    if (in_valid && !e_ud) begin
      es = imm_hi[3] ? 64 : imm_hi[2] ? 32 : 16;   // R1
      code = int'({imm_hi, imm_lo});
      f = 2 * es - code;                            // R2
      n = scalar ? 1 : (q_full ? 128 : 64) / es;    // R4, R5
      r = (scalar && merge_en) ? dst_old : '0;
      for (int i = 0; i < n; i++) begin
        mlane(64'(src_vec >> (i * es)) & ((es == 64) ? '1 : ((64'd1 << es) - 1)), es, f, v, li, lx);
        for (int bb = 0; bb < es; bb++) r[i*es + bb] = v[bb];
        e_inv |= li;
        e_inx |= lx;
      end
      e_res = r;
    end
  endtask

  task automatic compare();
    n_cmp++;
    if (out_valid !== e_ov || undef !== e_ud || result !== e_res ||
        flag_invalid !== e_inv || flag_inexact !== e_inx || nh_undef !== e_nhud) begin
      n_bad++;
      $display("FAIL %s: ov=%0b/%0b ud=%0b/%0b nhud=%0b/%0b res=%h/%h inv=%0b/%0b inx=%0b/%0b",
               cur_tag, out_valid, e_ov, undef, e_ud, nh_undef, e_nhud, result, e_res,
               flag_invalid, e_inv, flag_inexact, e_inx);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0;
    e_ov = 0; e_ud = 0; e_nhud = 0; e_inv = 0; e_inx = 0; e_res = '0;
    @(negedge clk);
    @(negedge clk);
    cur_tag = "R11 reset";
    compare();
    rst_n = 1'b1;
  endtask

  task automatic op(input string tag, input logic [6:0] code, input bit sc, input bit q,
                    input bit mg, input logic [127:0] src, input logic [127:0] old);
    cur_tag = tag;
    {imm_hi, imm_lo} = code;
    scalar = sc; q_full = q; merge_en = mg; src_vec = src; dst_old = old;
    in_valid = 1'b1;
    tick();
    in_valid = 1'b0;
  endtask

  localparam logic [127:0] OLD = 128'hA5A5_A5A5_5A5A_5A5A_C3C3_C3C3_3C3C_3C3C;

  bit done = 0;
  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_bad++;
        $display("FAIL watchdog: cycles=%0d expected completion", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    in_valid = 0; src_vec = '0; dst_old = '0; imm_hi = '0; imm_lo = '0;
    q_full = 0; scalar = 0; merge_en = 0; rst_n = 0;
    do_reset();
    // R1 R2 R6 R9: double 2D, fbits 1: 3.75 -> 7 inexact, 1.0 -> 2
    op("R6 2D f1", 7'd127, 0, 1, 0, {64'h3FF0000000000000, 64'h400E000000000000}, OLD);
    tick();   // idle: R11 hold
    cur_tag = "R11 idle";
    tick();
    // R8: 1.0 * 2^64 saturates; 1.5 * 2^10
    do_reset();
    op("R8 2D f64", 7'd64, 0, 1, 0, {64'h3FF0000000000000, 64'h0000000000000001}, OLD);
    op("R2 2D f10", 7'd118, 0, 1, 0, {64'h3FF8000000000000, 64'h3FF8000000000000}, OLD);
    // R7: negative small -> inexact only
    do_reset();
    op("R7 2D neg small", 7'd127, 0, 1, 0, {64'hBFD0000000000000, 64'h8000000000000000}, OLD);
    op("R7 2D neg big", 7'd127, 0, 1, 0, {64'hC000000000000000, 64'h0}, OLD);
    // R8: NaN / +inf / -inf
    do_reset();
    op("R8 2D nan inf", 7'd100, 0, 1, 0, {64'h7FF8000000000000, 64'h7FF0000000000000}, OLD);
    op("R8 2D -inf", 7'd100, 0, 1, 0, {64'hFFF0000000000000, 64'h0}, OLD);
    // R1 R4: single 2S and 4S
    do_reset();
    op("R4 2S f1", 7'd63, 0, 0, 0, {32'h3F800000, 32'h3F800000, 32'h40200000, 32'h3F000000}, OLD);
    op("R4 4S f8", 7'd56, 0, 1, 0, {32'h4F800000, 32'hBFC00000, 32'h40200000, 32'h3F000000}, OLD);
    op("R8 4S f32", 7'd32, 0, 1, 0, {32'h7FC00000, 32'h7F800000, 32'h3F800000, 32'h3F7FFFFF}, OLD);
    // half 4H, 8H
    do_reset();
    op("R4 4H f4", 7'd28, 0, 0, 0, {64'h7BFF_3E00_3C00_0001, 64'h3C00_3C00_3C00_3C00}, OLD);
    op("R6 8H f16", 7'd16, 0, 1, 0, {16'h7BFF, 16'h3E00, 16'h8000, 16'hB800,
                                      16'h0001, 16'h7C00, 16'h7E00, 16'h3C00}, OLD);
    // R5 scalar with and without merge, every width
    do_reset();
    op("R5 scalar D merge", 7'd127, 1, 0, 1, {64'h3FF0000000000000, 64'h400E000000000000}, OLD);
    op("R5 scalar S nomerge", 7'd63, 1, 1, 0, {96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 32'h40200000}, OLD);
    op("R5 scalar H merge", 7'd31, 1, 0, 1, {112'h7C00_7C00, 16'h3E00}, OLD);
    // R10: inactive lanes hold NaN, flags must stay clear
    do_reset();
    op("R10 inactive lanes", 7'd63, 0, 0, 0, {32'h7FC00000, 32'h7FC00000, 32'h3F800000, 32'h3F800000}, OLD);
    op("R10 scalar inactive", 7'd31, 1, 1, 0, {112'h7E00_7E00_7E00, 16'h3C00}, OLD);
    // R3 undefined encodings: result and flags frozen
    op("R3 immh 0001", 7'd12, 0, 1, 0, {128{1'b1}}, OLD);
    op("R3 D with q0", 7'd127, 0, 0, 0, {64'h7FF8000000000000, 64'h7FF8000000000000}, OLD);
    op("R3 half disabled", 7'd20, 0, 1, 0, {8{16'h3C00}}, OLD);
    op("R3 scalar D q0 ok", 7'd120, 1, 0, 0, {64'h0, 64'h3FF0000000000000}, OLD);
    // mixed pseudo-random traffic with periodic reset
    for (int k = 0; k < 400; k++) begin
      if (k % 16 == 0) do_reset();
      op("R6 random", 7'($urandom_range(0, 127)), 1'($urandom), 1'($urandom), 1'($urandom),
         {$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom});
      if (k % 5 == 0) begin cur_tag = "R11 gap"; tick(); end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule